// File: doc/BRIEF.md
# Framed Link Packet Receiver

This block sits behind a double-data-rate capture stage that has already turned the link into one byte per link-clock edge plus a frame flag. It detects where a packet starts, counts the bytes of a short (9-byte) or long (13-byte) packet, and assembles them into a 104-bit mesh transaction. A frame flag that stays high past the last byte chains a further packet that omits the header and address bytes, so back-to-back traffic to consecutive addresses costs only the payload bytes.

Each completed transaction is shown for one cycle on a strobe and is also steered by its write bit into one of two small buffers, one for reads and one for writes. The consumer drains each buffer with a pop input. Each buffer raises its own wait output to throttle the far-end transmitter. The wait rises late enough to follow the link's timing rule, and the buffer still has room for one more full packet after the wait is seen.

Top module: `lrx_link_rx`

## Requirements
- R1: A byte is taken as byte 0 only when frame is high on that edge and was low on the previous edge. A frame that is already high when reset is released does not count as a start.
- R2: Byte 0 carries ctrlmode in bits [7:4], write in bit 3, the long-packet flag in bit 2 and datamode in bits [1:0]. Bytes 1–4 carry dstaddr and bytes 5–8 carry data, each most significant byte first. A long packet adds srcaddr in bytes 9–12. A short packet reports srcaddr as zero.
- R3: The transaction is packed as {access, write, datamode[1:0], ctrlmode[3:0], dstaddr[31:0], data[31:0], srcaddr[31:0]}, with access in bit 103, and access is always 1.
- R4: If frame is low on the edge after the last byte (byte 8 or byte 12), the packet ends with exactly one transaction.
- R5: If frame is high on the edge after the last byte, that edge's byte is byte 5 of a new transaction. The new transaction keeps the header fields and uses dstaddr plus 8. Its data, and its srcaddr when the packet is long, come from the new bytes.
- R6: The completion strobe is high for exactly one cycle, in the cycle after the edge that captured the last byte.
- R7: A transaction with write=1 enters the write buffer, and one with write=0 enters the read buffer.
- R8: A buffer's wait output rises on the second edge after the edge that captured the last byte of a transaction placed in that buffer.
- R9: Each buffer holds two transactions, so one more full packet is accepted after wait rises. The head is presented in arrival order. A transaction arriving while the buffer is full is dropped.
- R10: When frame falls before the last byte of a packet, the partial packet is discarded and no transaction is produced.
- R11: A wait output falls one edge after its buffer has been emptied by pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one byte per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| link_frame | input | 1 | Frame flag sampled with each byte |
| link_byte | input | 8 | Deserialized link byte |
| txn_valid | output | 1 | One-cycle strobe for a completed transaction |
| txn_data | output | 104 | Completed transaction |
| rd_pop | input | 1 | Remove the head of the read buffer |
| rd_valid | output | 1 | Read buffer holds an entry |
| rd_txn | output | 104 | Head of the read buffer |
| rd_wait | output | 1 | Read push-back to the transmitter |
| wr_pop | input | 1 | Remove the head of the write buffer |
| wr_valid | output | 1 | Write buffer holds an entry |
| wr_txn | output | 104 | Head of the write buffer |
| wr_wait | output | 1 | Write push-back to the transmitter |

## Verification
The hardest cases to reach are the chained transitions. One is a frame still high on the edge after the last byte, where that same byte has to be read as byte 5. The other is a frame that stays high straight out of reset. The stimulus builds byte streams that chain short and long packets without a gap, and it holds frame high across the release of reset. The stimulus also sweeps every combination of ctrlmode, datamode, write and length. For each transaction the bench computes the expected value from the field layout, and it checks the wait edges cycle by cycle against the buffers left undrained.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 32;
    localparam int TXN_W       = 104;
    localparam int SHORT_LAST  = 8;
    localparam int LONG_LAST   = 12;
    localparam int STREAM_IDX  = 5;
    localparam logic [ADDR_W-1:0] ADDR_STEP = 32'd8;

    typedef struct packed {
        logic [3:0] ctrlmode;
        logic       write;
        logic       long_pkt;
        logic [1:0] datamode;
    } hdr_t;

    typedef struct packed {
        logic              access;
        logic              write;
        logic [1:0]        datamode;
        logic [3:0]        ctrlmode;
        logic [ADDR_W-1:0] dstaddr;
        logic [ADDR_W-1:0] data;
        logic [ADDR_W-1:0] srcaddr;
    } mesh_txn_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_BODY,
        RX_TAIL
    } rx_state_e;

    function automatic hdr_t decode_hdr(input logic [BYTE_W-1:0] b);
        hdr_t h;
        h.ctrlmode = b[7:4];
        h.write    = b[3];
        h.long_pkt = b[2];
        h.datamode = b[1:0];
        return h;
    endfunction

    function automatic logic [3:0] last_index(input hdr_t h);
        return h.long_pkt ? 4'(LONG_LAST) : 4'(SHORT_LAST);
    endfunction

    function automatic mesh_txn_t pack_txn(input hdr_t h,
                                           input logic [ADDR_W-1:0] dst,
                                           input logic [ADDR_W-1:0] dat,
                                           input logic [ADDR_W-1:0] src);
        mesh_txn_t t;
        t.access   = 1'b1;
        t.write    = h.write;
        t.datamode = h.datamode;
        t.ctrlmode = h.ctrlmode;
        t.dstaddr  = dst;
        t.data     = dat;
        t.srcaddr  = h.long_pkt ? src : '0;
        return t;
    endfunction

endpackage

// File: rtl/lrx_framer.sv
module lrx_framer
    import lrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              done_o,
    output mesh_txn_t         txn_o
);

    rx_state_e         state_q;
    logic [3:0]        idx_q;
    logic              frame_q;
    hdr_t              hdr_q;
    logic [ADDR_W-1:0] dst_q;
    logic [ADDR_W-1:0] dat_q;
    logic [ADDR_W-1:0] src_q;

    logic              start_seen;
    logic              at_last;
    logic [ADDR_W-1:0] dst_shift;
    logic [ADDR_W-1:0] dat_shift;
    logic [ADDR_W-1:0] src_shift;

    always_comb begin
        start_seen = frame_i && !frame_q;
        at_last    = (idx_q == last_index(hdr_q));
        dst_shift  = {dst_q[ADDR_W-BYTE_W-1:0], byte_i};
        dat_shift  = {dat_q[ADDR_W-BYTE_W-1:0], byte_i};
        src_shift  = {src_q[ADDR_W-BYTE_W-1:0], byte_i};
    end

    // byte collection and streaming control
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            frame_q <= 1'b1;
            hdr_q   <= '0;
            dst_q   <= '0;
            dat_q   <= '0;
            src_q   <= '0;
        end else begin
            frame_q <= frame_i;
            unique case (state_q)
                RX_IDLE: begin
                    if (start_seen) begin
                        hdr_q   <= decode_hdr(byte_i);
                        idx_q   <= 4'd1;
                        state_q <= RX_BODY;
                    end
                end
                RX_BODY: begin
                    if (!frame_i) begin
                        state_q <= RX_IDLE;
                    end else begin
                        if (idx_q <= 4'd4)
                            dst_q <= dst_shift;
                        else if (idx_q <= 4'(SHORT_LAST))
                            dat_q <= dat_shift;
                        else
                            src_q <= src_shift;
                        if (at_last)
                            state_q <= RX_TAIL;
                        else
                            idx_q <= idx_q + 4'd1;
                    end
                end
                RX_TAIL: begin
                    if (frame_i) begin
                        dst_q   <= dst_q + ADDR_STEP;
                        dat_q   <= dat_shift;
                        idx_q   <= 4'(STREAM_IDX + 1);
                        state_q <= RX_BODY;
                    end else begin
                        state_q <= RX_IDLE;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // completion register: one-cycle strobe with the assembled transaction
    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            txn_o  <= '0;
        end else begin
            done_o <= (state_q == RX_BODY) && frame_i && at_last;
            if ((state_q == RX_BODY) && frame_i && at_last) begin
                if (hdr_q.long_pkt)
                    txn_o <= pack_txn(hdr_q, dst_q, dat_q, src_shift);
                else
                    txn_o <= pack_txn(hdr_q, dst_q, dat_shift, '0);
            end
        end
    end

endmodule

// File: rtl/lrx_skid.sv
module lrx_skid #(
    parameter int WIDTH      = 104,
    parameter int DEPTH      = 2,
    parameter int WAIT_LEVEL = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] head_o,
    output logic             wait_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] WAIT_CNT = CNT_W'(WAIT_LEVEL);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    always_comb begin
        do_pop  = pop_i && (cnt_q != '0);
        do_push = push_i && (cnt_q != FULL_CNT);
        valid_o = (cnt_q != '0);
        head_o  = mem_q[rptr_q];
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem_q[wptr_q] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            wait_o <= 1'b0;
        end else begin
            if (do_push)
                wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
            if (do_pop)
                rptr_q <= (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
            cnt_q  <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
            // registered from the current level: rises one edge after the entry lands
            wait_o <= (cnt_q >= WAIT_CNT);
        end
    end

endmodule

// File: rtl/lrx_link_rx.sv
module lrx_link_rx
    import lrx_pkg::*;
#(
    parameter int BUF_DEPTH  = 2,
    parameter int WAIT_LEVEL = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_frame,
    input  logic [7:0]        link_byte,
    output logic              txn_valid,
    output logic [TXN_W-1:0]  txn_data,
    input  logic              rd_pop,
    output logic              rd_valid,
    output logic [TXN_W-1:0]  rd_txn,
    output logic              rd_wait,
    input  logic              wr_pop,
    output logic              wr_valid,
    output logic [TXN_W-1:0]  wr_txn,
    output logic              wr_wait
);

    localparam int N_DIR = 2;   // index 0 read, index 1 write

    mesh_txn_t        done_txn;
    logic             done;
    logic             push_v [N_DIR];
    logic             pop_v  [N_DIR];
    logic             val_v  [N_DIR];
    logic             wait_v [N_DIR];
    logic [TXN_W-1:0] head_v [N_DIR];

    lrx_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .frame_i (link_frame),
        .byte_i  (link_byte),
        .done_o  (done),
        .txn_o   (done_txn)
    );

    assign txn_valid = done;
    assign txn_data  = done_txn;
    assign pop_v[0]  = rd_pop;
    assign pop_v[1]  = wr_pop;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        assign push_v[d] = done && (done_txn.write == 1'(d));
        lrx_skid #(
            .WIDTH      (TXN_W),
            .DEPTH      (BUF_DEPTH),
            .WAIT_LEVEL (WAIT_LEVEL)
        ) u_buf (
            .clk     (clk),
            .rst     (rst),
            .push_i  (push_v[d]),
            .din_i   (done_txn),
            .pop_i   (pop_v[d]),
            .valid_o (val_v[d]),
            .head_o  (head_v[d]),
            .wait_o  (wait_v[d])
        );
    end

    assign rd_valid = val_v[0];
    assign rd_txn   = head_v[0];
    assign rd_wait  = wait_v[0];
    assign wr_valid = val_v[1];
    assign wr_txn   = head_v[1];
    assign wr_wait  = wait_v[1];

endmodule

// File: rtl/lrx_link_rx_chk.sv
module lrx_link_rx_chk (
    input logic         clk,
    input logic         rst,
    input logic         link_frame,
    input logic [7:0]   link_byte,
    input logic         txn_valid,
    input logic [103:0] txn_data,
    input logic         rd_pop,
    input logic         rd_valid,
    input logic [103:0] rd_txn,
    input logic         rd_wait,
    input logic         wr_pop,
    input logic         wr_valid,
    input logic [103:0] wr_txn,
    input logic         wr_wait
);

    assert_access_set_R3: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> txn_data[103]);

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> !txn_valid);

    assert_read_steer_R7: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_data[102] && !rd_valid) |=> (rd_valid && rd_txn == $past(txn_data)));

    assert_write_steer_R7: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_data[102] && !wr_valid) |=> (wr_valid && wr_txn == $past(txn_data)));

    assert_wait_not_early_R8: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_data[102] && !wr_valid && !wr_wait) |=> !wr_wait);

    assert_wait_after_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_wait) |-> $past(rd_valid));

    assert_head_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_pop) |=> (wr_valid && $stable(wr_txn)));

    assert_wait_release_R11: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid && !txn_valid) |=> !wr_wait);

endmodule

bind lrx_link_rx lrx_link_rx_chk u_chk (.*);

// File: tb/sim_lrx_link_rx.sv
module sim_lrx_link_rx;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         link_frame = 1'b0;
    logic [7:0]   link_byte = 8'h00;
    logic         rd_pop = 1'b0;
    logic         wr_pop = 1'b0;
    logic         txn_valid, rd_valid, rd_wait, wr_valid, wr_wait;
    logic [103:0] txn_data, rd_txn, wr_txn;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lrx_link_rx u0 (
        .clk(clk), .rst(rst), .link_frame(link_frame), .link_byte(link_byte),
        .txn_valid(txn_valid), .txn_data(txn_data),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_txn(rd_txn), .rd_wait(rd_wait),
        .wr_pop(wr_pop), .wr_valid(wr_valid), .wr_txn(wr_txn), .wr_wait(wr_wait)
    );

    // stimulus byte list and expected transaction queue
    logic [7:0]   bytes [0:255];
    int           nbytes = 0;
    logic [103:0] exp_q [0:1023];
    int           exp_wr = 0;
    int           exp_rd = 0;

    logic        cur_w, cur_long;
    logic [1:0]  cur_dm;
    logic [3:0]  cur_cm;
    logic [31:0] cur_dst;

    task automatic chk(input string tag, input logic [103:0] act, input logic [103:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [103:0] mk(input logic w, input logic lng, input logic [1:0] dm,
                                        input logic [3:0] cm, input logic [31:0] dst,
                                        input logic [31:0] dat, input logic [31:0] src);
        return {1'b1, w, dm, cm, dst, dat, (lng ? src : 32'h0)};
    endfunction

    task automatic put(input logic [7:0] b);
        bytes[nbytes] = b;
        nbytes++;
    endtask

    task automatic put32(input logic [31:0] v);
        put(v[31:24]); put(v[23:16]); put(v[15:8]); put(v[7:0]);
    endtask

    task automatic add_pkt(input logic w, input logic lng, input logic [1:0] dm, input logic [3:0] cm,
                           input logic [31:0] dst, input logic [31:0] dat, input logic [31:0] src);
        put({cm, w, lng, dm});
        put32(dst);
        put32(dat);
        if (lng) put32(src);
        exp_q[exp_wr] = mk(w, lng, dm, cm, dst, dat, src);
        exp_wr++;
        cur_w = w; cur_long = lng; cur_dm = dm; cur_cm = cm; cur_dst = dst;
    endtask

    task automatic add_stream(input logic [31:0] dat, input logic [31:0] src);
        cur_dst = cur_dst + 32'd8;
        put32(dat);
        if (cur_long) put32(src);
        exp_q[exp_wr] = mk(cur_w, cur_long, cur_dm, cur_cm, cur_dst, dat, src);
        exp_wr++;
    endtask

    task automatic drive(input logic f, input logic [7:0] b);
        @(negedge clk);
        link_frame = f;
        link_byte  = b;
    endtask

    // sends the list with frame high, then one low-frame cycle
    task automatic fire();
        for (int k = 0; k < nbytes; k++) drive(1'b1, bytes[k]);
        drive(1'b0, 8'h00);
        nbytes = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 8'h00);
    endtask

    task automatic pop_wr();
        @(negedge clk); wr_pop = 1'b1;
        @(negedge clk); wr_pop = 1'b0;
    endtask

    task automatic pop_rd();
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    // strobe monitor: every completion matches the next expected transaction (R2 R3 R4 R5 R6)
    always @(negedge clk) begin
        if (!rst && txn_valid) begin
            if (exp_rd >= exp_wr) begin
                checks++; errors++;
                $display("FAIL R10 unexpected transaction actual=%h expected=none", txn_data);
            end else begin
                chk("R2 R3 R5 strobe content", txn_data, exp_q[exp_rd]);
                exp_rd++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: frame already high across reset release must not start a packet
        link_frame = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset strobe", {103'b0, txn_valid}, 104'b0);
        chk("R1 reset buffers", {100'b0, rd_valid, wr_valid, rd_wait, wr_wait}, 104'b0);
        for (int k = 0; k < 20; k++) drive(1'b1, 8'h0C);
        idle(3);
        chk("R1 no start without rising edge", 104'(exp_rd), 104'(exp_wr));
        chk("R1 buffers empty", {102'b0, rd_valid, wr_valid}, 104'b0);

        // R8: write packet, wait rises on the second edge after the last byte
        add_pkt(1'b1, 1'b0, 2'b10, 4'h3, 32'h8000_1000, 32'hCAFE_0001, 32'h0);
        for (int k = 0; k < nbytes; k++) drive(1'b1, bytes[k]);
        nbytes = 0;
        drive(1'b0, 8'h00);
        chk("R6 strobe after last-byte edge", {103'b0, txn_valid}, 104'd1);
        chk("R8 wait low one edge after", {103'b0, wr_wait}, 104'b0);
        drive(1'b0, 8'h00);
        chk("R6 strobe gone", {103'b0, txn_valid}, 104'b0);
        chk("R7 write entered write buffer", {103'b0, wr_valid}, 104'd1);
        chk("R8 wait still low", {103'b0, wr_wait}, 104'b0);
        drive(1'b0, 8'h00);
        chk("R8 wait high on second edge", {103'b0, wr_wait}, 104'd1);
        chk("R7 read buffer untouched", {102'b0, rd_valid, rd_wait}, 104'b0);

        // R9: a second full packet is still accepted, a third is dropped
        add_pkt(1'b1, 1'b1, 2'b11, 4'hA, 32'h0000_2000, 32'h1111_2222, 32'h3333_4444);
        fire(); idle(2);
        add_pkt(1'b1, 1'b0, 2'b00, 4'h5, 32'h0000_3000, 32'h5555_6666, 32'h0);
        fire(); idle(2);
        chk("R9 head is first", wr_txn, exp_q[exp_wr-3]);
        pop_wr();
        chk("R9 head is second", wr_txn, exp_q[exp_wr-2]);
        pop_wr();
        chk("R9 third dropped", {103'b0, wr_valid}, 104'b0);
        chk("R11 wait still high right after drain", {103'b0, wr_wait}, 104'd1);
        idle(1);
        chk("R11 wait falls", {103'b0, wr_wait}, 104'b0);

        // R5: short read packet followed by two streamed packets
        add_pkt(1'b0, 1'b0, 2'b01, 4'h9, 32'h4000_0000, 32'hA0A0_0001, 32'h0);
        add_stream(32'hA0A0_0002, 32'h0);
        add_stream(32'hA0A0_0003, 32'h0);
        fire(); idle(2);
        chk("R4 R5 three transactions", 104'(exp_rd), 104'(exp_wr));
        chk("R7 read buffer filled", {103'b0, rd_valid}, 104'd1);
        pop_rd(); pop_rd(); idle(2);

        // R5: long write packet streamed once, srcaddr refreshed
        add_pkt(1'b1, 1'b1, 2'b11, 4'h2, 32'h7FFF_FFF8, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        add_stream(32'h1234_5678, 32'h9ABC_DEF0);
        fire(); idle(2);
        chk("R5 long stream head", wr_txn, exp_q[exp_wr-2]);
        pop_wr();
        chk("R5 long stream second", wr_txn, exp_q[exp_wr-1]);
        pop_wr(); idle(2);

        // R10: frame falls mid-packet, nothing produced, then a clean packet
        drive(1'b1, 8'h08); drive(1'b1, 8'h11); drive(1'b1, 8'h22); drive(1'b1, 8'h33);
        idle(4);
        chk("R10 partial discarded", {102'b0, rd_valid, wr_valid}, 104'b0);
        chk("R10 no strobe", 104'(exp_rd), 104'(exp_wr));

        // near-exhaustive header sweep: every ctrlmode, datamode, write and length
        for (int i = 0; i < 256; i++) begin
            logic w, lng;
            logic [1:0] dm;
            logic [3:0] cm;
            logic [31:0] dst, dat;
            w   = i[0];
            lng = i[1];
            dm  = i[3:2];
            cm  = i[7:4];
            dst = 32'h1000_0000 + 32'(i) * 32'h0101_0013;
            dat = 32'(i) * 32'h9E37_79B9;
            add_pkt(w, lng, dm, cm, dst, dat, ~dat);
            fire(); idle(2);
            if (w) begin
                chk("R2 R7 sweep write head", wr_txn, exp_q[exp_wr-1]);
                chk("R7 sweep read empty", {103'b0, rd_valid}, 104'b0);
                pop_wr();
            end else begin
                chk("R2 R7 sweep read head", rd_txn, exp_q[exp_wr-1]);
                chk("R7 sweep write empty", {103'b0, wr_valid}, 104'b0);
                pop_rd();
            end
        end
        idle(3);
        chk("R4 all transactions seen", 104'(exp_rd), 104'(exp_wr));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule